// File: doc/BRIEF.md
# Transmit Jabber and Babble Watchdog

This block sits beside a transmit engine and watches for two transmitter faults. The first fault is a transmitter that stays on the line for too long. When transmit-active has been high for a set number of consecutive cycles, the block raises an inhibit output that forces the transmit bit stream off. The inhibit stays high until transmit-active has dropped and a recovery period has then run out. This check applies only on the twisted-pair and direct-interface port selections. The second fault is an oversized frame. Byte strobes within one frame are counted, and a flag is raised when the count reaches the maximum frame length. That frame is still allowed to finish.

Both faults set sticky bits in a two-bit status register. Reading the register clears it, and a hardware or software reset also clears it. An interrupt output stays high while any status bit is set. All timer lengths are parameters given in clock cycles. The defaults are 20 ms for the jabber limit and 0.5 s for recovery at 125 MHz, with a 1519-byte frame limit.

Top module: `tx_guard`

## Requirements
- R1: After the synchronous active-low reset, `tx_inhibit` is 0, `status` is 0 and `irq` is 0.
- R2: With `port_sel` at 1 (twisted pair) or 2 (direct interface), the clock edge that samples `tx_active` high for the JAB_CYCLES-th consecutive time sets `tx_inhibit` and `status[0]` (jabber) together.
- R3: A cycle with `tx_active` low before the limit is reached restarts the consecutive-activity count, so 39 active cycles, then a gap, then 39 more never trip a 40-cycle limit.
- R4: Once tripped, `tx_inhibit` stays high while `tx_active` is high. It falls on the UNJAB_CYCLES-th edge after the first edge that samples `tx_active` low. If `tx_active` rises during recovery, recovery starts over.
- R5: With `port_sel` at 0 (coax attachment) or 3 (serial), jabber detection is off. `tx_inhibit` stays 0 and `status[0]` is never set, and switching to these ports ends an ongoing inhibit on the next edge.
- R6: `status[1]` (babble) is set on the edge that samples the MAX_BYTES-th byte strobe of a frame. `tx_inhibit` is not affected.
- R7: The byte count restarts whenever `tx_active` is low. Byte strobes sampled while `tx_active` is low are not counted.
- R8: A cycle with `stat_rd` high clears every status bit that has no new event in that cycle.
- R9: An event in the same cycle as `stat_rd` leaves its status bit set.
- R10: `sw_rst` high clears the status bits, drops `tx_inhibit` and restarts both counters on the next edge.
- R11: `irq` is 1 exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst | input | 1 | Software reset, clears state and status |
| tx_active | input | 1 | High while the transmitter drives the line |
| byte_stb | input | 1 | One pulse per transmitted byte |
| port_sel | input | 2 | Port: 0 coax attachment, 1 twisted pair, 2 direct, 3 serial |
| stat_rd | input | 1 | Status read strobe; the read clears the bits |
| tx_inhibit | output | 1 | Forces the transmit stream off |
| status | output | 2 | Bit 0 jabber, bit 1 babble |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Jabber is driven with an active run one cycle short of the limit and then with a run exactly at the limit, which separates an off-by-one trip from a correct one. Activity raised again during recovery shows whether recovery restarts or only pauses, and the same long bursts on the coax and serial selections show whether the port gate works. For babble, frames of 19, 20 and 25 bytes, stray strobes while idle, and back-to-back 19-byte frames separate a counter that restarts per frame from one that leaks across frames. A read placed on the exact cycle of a babble event shows whether a coincident event is lost.

// File: rtl/tx_guard_pkg.sv
// Shared definitions for the transmit watchdog.
// Assumes port selection codes are fixed by the surrounding MAC configuration.
package tx_guard_pkg;

    typedef enum logic [1:0] {
        JG_RUN     = 2'd0,
        JG_CUT     = 2'd1,
        JG_RECOVER = 2'd2
    } jab_state_t;

    localparam int STAT_W    = 2;
    localparam int STAT_JAB  = 0;
    localparam int STAT_BABL = 1;

    localparam logic [1:0] PSEL_COAX   = 2'd0;
    localparam logic [1:0] PSEL_TWPAIR = 2'd1;
    localparam logic [1:0] PSEL_DIRECT = 2'd2;
    localparam logic [1:0] PSEL_SERIAL = 2'd3;

    // True for port selections on which the jabber check applies.
    function automatic logic jab_capable(input logic [1:0] psel);
        return (psel == PSEL_TWPAIR) || (psel == PSEL_DIRECT);
    endfunction

endpackage

// File: rtl/jabber_timer.sv
// Jabber timer: counts consecutive active cycles and cuts the transmitter
// when the limit is reached, then holds the cut through a recovery period
// that starts once activity stops. Assumes JAB_CYCLES, UNJAB_CYCLES >= 2.
module jabber_timer
    import tx_guard_pkg::*;
#(
    parameter int JAB_CYCLES   = 2_500_000,
    parameter int UNJAB_CYCLES = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic enable,
    input  logic tx_active,
    output logic inhibit,
    output logic trip
);
    localparam int JW = $clog2(JAB_CYCLES + 1);
    localparam int UW = $clog2(UNJAB_CYCLES + 1);
    localparam logic [JW-1:0] JAB_LAST   = JW'(JAB_CYCLES - 1);
    localparam logic [UW-1:0] UNJAB_LAST = UW'(UNJAB_CYCLES - 1);

    jab_state_t     state_q;
    logic [JW-1:0]  run_cnt_q;
    logic [UW-1:0]  rec_cnt_q;

    // Trip pulse: limit reached on this edge while still running.
    always_comb begin
        trip = enable && !sw_rst && (state_q == JG_RUN)
            && tx_active && (run_cnt_q == JAB_LAST);
    end

    // Inhibit whenever the timer is not in the running state.
    always_comb begin
        inhibit = (state_q != JG_RUN);
    end

    // State and counters for activity and recovery timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= JG_RUN;
            run_cnt_q <= '0;
            rec_cnt_q <= '0;
        end else if (sw_rst || !enable) begin
            state_q   <= JG_RUN;
            run_cnt_q <= '0;
            rec_cnt_q <= '0;
        end else begin
            unique case (state_q)
                JG_RUN: begin
                    if (!tx_active) begin
                        run_cnt_q <= '0;
                    end else if (run_cnt_q == JAB_LAST) begin
                        state_q   <= JG_CUT;
                        run_cnt_q <= '0;
                    end else begin
                        run_cnt_q <= run_cnt_q + 1'b1;
                    end
                end
                JG_CUT: begin
                    if (!tx_active) begin
                        state_q   <= JG_RECOVER;
                        rec_cnt_q <= '0;
                    end
                end
                JG_RECOVER: begin
                    if (tx_active) begin
                        state_q <= JG_CUT;
                    end else if (rec_cnt_q == UNJAB_LAST) begin
                        state_q   <= JG_RUN;
                        rec_cnt_q <= '0;
                    end else begin
                        rec_cnt_q <= rec_cnt_q + 1'b1;
                    end
                end
                default: state_q <= JG_RUN;
            endcase
        end
    end

endmodule

// File: rtl/babble_counter.sv
// Babble counter: counts byte strobes within one frame and pulses once when
// the count reaches MAX_BYTES. It never stops the frame. Assumes a frame is
// one unbroken run of tx_active high.
module babble_counter #(
    parameter int MAX_BYTES = 1519
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic tx_active,
    input  logic byte_stb,
    output logic trip
);
    localparam int BW = $clog2(MAX_BYTES + 1);
    localparam logic [BW-1:0] BYTE_MAX  = BW'(MAX_BYTES);
    localparam logic [BW-1:0] BYTE_LAST = BW'(MAX_BYTES - 1);

    logic [BW-1:0] cnt_q;

    // Pulse on the strobe that brings the count to the limit.
    always_comb begin
        trip = !sw_rst && tx_active && byte_stb && (cnt_q == BYTE_LAST);
    end

    // Saturating per-frame byte count, cleared between frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sw_rst || !tx_active) begin
            cnt_q <= '0;
        end else if (byte_stb && (cnt_q != BYTE_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/guard_status.sv
// Clear-on-read status register: each bit is set by its event and cleared
// by a read, and an event in the read cycle wins. Assumes event pulses last
// one cycle.
module guard_status #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_rst,
    input  logic         rd,
    input  logic [W-1:0] evt,
    output logic [W-1:0] status
);
    logic [W-1:0] bits_q;

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        // One sticky bit with clear-on-read and reset.
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst) begin
                bits_q[gi] <= 1'b0;
            end else if (evt[gi]) begin
                bits_q[gi] <= 1'b1;
            end else if (rd) begin
                bits_q[gi] <= 1'b0;
            end
        end
    end

    assign status = bits_q;

endmodule

// File: rtl/tx_guard.sv
// Transmit watchdog top: joins the jabber timer, the babble counter and the
// clear-on-read status register, and raises the interrupt from the status.
// Assumes all inputs are synchronous to clk.
module tx_guard
    import tx_guard_pkg::*;
#(
    parameter int JAB_CYCLES   = 2_500_000,
    parameter int UNJAB_CYCLES = 62_500_000,
    parameter int MAX_BYTES    = 1519
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_rst,
    input  logic        tx_active,
    input  logic        byte_stb,
    input  logic [1:0]  port_sel,
    input  logic        stat_rd,
    output logic        tx_inhibit,
    output logic [1:0]  status,
    output logic        irq
);
    logic              jab_en;
    logic              jab_trip;
    logic              babl_trip;
    logic [STAT_W-1:0] evt;

    // Port gate for the jabber check.
    always_comb begin
        jab_en = jab_capable(port_sel);
    end

    jabber_timer #(
        .JAB_CYCLES   (JAB_CYCLES),
        .UNJAB_CYCLES (UNJAB_CYCLES)
    ) u_jab (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .enable    (jab_en),
        .tx_active (tx_active),
        .inhibit   (tx_inhibit),
        .trip      (jab_trip)
    );

    babble_counter #(
        .MAX_BYTES (MAX_BYTES)
    ) u_babl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .tx_active (tx_active),
        .byte_stb  (byte_stb),
        .trip      (babl_trip)
    );

    // Route event pulses to their status bit positions.
    always_comb begin
        evt            = '0;
        evt[STAT_JAB]  = jab_trip;
        evt[STAT_BABL] = babl_trip;
    end

    guard_status #(
        .W (STAT_W)
    ) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .rd     (stat_rd),
        .evt    (evt),
        .status (status)
    );

    // Interrupt while any status bit is pending.
    always_comb begin
        irq = |status;
    end

endmodule

// File: rtl/tx_guard_chk.sv
// Property checker for tx_guard, attached by bind.
module tx_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_rst,
    input logic       tx_active,
    input logic [1:0] port_sel,
    input logic       stat_rd,
    input logic       tx_inhibit,
    input logic [1:0] status,
    input logic       irq,
    input logic       jab_evt,
    input logic       babl_evt
);
    logic past_capable;
    assign past_capable = (port_sel == 2'd1) || (port_sel == 2'd2);

    // R5: inhibit only follows an edge on a jabber-capable port
    p_inhibit_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit |-> $past(past_capable));

    // R5: no jabber event on other ports
    p_no_jab_off_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !past_capable |-> !jab_evt);

    // R2: jabber flag rises together with the inhibit
    p_jab_with_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $rose(tx_inhibit));

    // R4: release only after idle, port change or software reset
    p_release_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_inhibit) |-> (!$past(tx_active) || !$past(past_capable) || $past(sw_rst)));

    // R8: a read with no event leaves the register empty
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !jab_evt && !babl_evt) |=> (status == 2'b00));

    // R9: a babble event during a read is kept
    p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (babl_evt && stat_rd && !sw_rst) |=> status[1]);

    // R11: no interrupt after a clearing read
    p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !jab_evt && !babl_evt) |=> !irq);

    // R10: software reset empties status and drops inhibit
    p_swrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (status == 2'b00 && !tx_inhibit));

endmodule

bind tx_guard tx_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .tx_active  (tx_active),
    .port_sel   (port_sel),
    .stat_rd    (stat_rd),
    .tx_inhibit (tx_inhibit),
    .status     (status),
    .irq        (irq),
    .jab_evt    (jab_trip),
    .babl_evt   (babl_trip)
);

// File: tb/tx_guard_test.sv
module tx_guard_test;
    localparam int J = 40;
    localparam int U = 30;
    localparam int M = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0;
    logic       tx_active = 1'b0;
    logic       byte_stb = 1'b0;
    logic [1:0] port_sel = 2'd1;
    logic       stat_rd = 1'b0;
    logic       tx_inhibit;
    logic [1:0] status;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tx_guard #(.JAB_CYCLES(J), .UNJAB_CYCLES(U), .MAX_BYTES(M)) uut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .tx_active(tx_active),
        .byte_stb(byte_stb), .port_sel(port_sel), .stat_rd(stat_rd),
        .tx_inhibit(tx_inhibit), .status(status), .irq(irq)
    );

    // Behavioural reference: mode 0 free, 1 cut, 2 recovering.
    int m_mode = 0, m_run = 0, m_rec = 0, m_bytes = 0;
    bit m_jf = 0, m_bf = 0;

    always @(posedge clk) begin
        bit jev, bev, en;
        jev = 0; bev = 0;
        en = (port_sel == 2'd1) || (port_sel == 2'd2);
        if (!rst_n || sw_rst) begin
            m_mode = 0; m_run = 0; m_rec = 0; m_bytes = 0; m_jf = 0; m_bf = 0;
        end else begin
            if (!en) begin
                m_mode = 0; m_run = 0; m_rec = 0;
            end else if (m_mode == 0) begin
                if (!tx_active) m_run = 0;
                else if (m_run + 1 >= J) begin m_mode = 1; m_run = 0; jev = 1; end
                else m_run++;
            end else if (m_mode == 1) begin
                if (!tx_active) begin m_mode = 2; m_rec = 0; end
            end else begin
                if (tx_active) m_mode = 1;
                else if (m_rec + 1 >= U) begin m_mode = 0; m_rec = 0; end
                else m_rec++;
            end
            if (!tx_active) m_bytes = 0;
            else if (byte_stb && m_bytes < M) begin
                m_bytes++;
                if (m_bytes == M) bev = 1;
            end
            if (stat_rd) begin m_jf = 0; m_bf = 0; end
            if (jev) m_jf = 1;
            if (bev) m_bf = 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 inhibit vs model", int'(tx_inhibit), int'(m_mode != 0));
            chk("R2 jabber bit vs model", int'(status[0]), int'(m_jf));
            chk("R6 babble bit vs model", int'(status[1]), int'(m_bf));
            chk("R11 irq vs model", int'(irq), int'(m_jf | m_bf));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_clear();
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    endtask

    task automatic send_frame(input int nbytes, input int rd_at);
        tx_active = 1'b1;
        for (int i = 0; i < nbytes; i++) begin
            byte_stb = 1'b1;
            stat_rd = (i == rd_at);
            cyc(1);
            byte_stb = 1'b0;
            stat_rd = 1'b0;
            cyc(1);
        end
        tx_active = 1'b0;
        cyc(1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 inhibit after reset", int'(tx_inhibit), 0);
        chk("R1 status after reset", int'(status), 0);
        chk("R1 irq after reset", int'(irq), 0);

        // R3: one short of the limit, then a gap
        tx_active = 1'b1; cyc(J - 1);
        tx_active = 1'b0; cyc(1);
        tx_active = 1'b1; cyc(J - 1);
        tx_active = 1'b0; cyc(1);
        chk("R3 no trip after split bursts", int'(tx_inhibit), 0);
        chk("R3 no jabber flag", int'(status[0]), 0);

        // R2: exact limit
        tx_active = 1'b1; cyc(J);
        chk("R2 inhibit at limit", int'(tx_inhibit), 1);
        chk("R2 jabber flag at limit", int'(status[0]), 1);
        chk("R11 irq with jabber", int'(irq), 1);
        cyc(10);
        chk("R4 held while active", int'(tx_inhibit), 1);
        tx_active = 1'b0; cyc(U - 1);
        chk("R4 held during recovery", int'(tx_inhibit), 1);
        tx_active = 1'b1; cyc(2);
        tx_active = 1'b0; cyc(U);
        chk("R4 recovery restarted", int'(tx_inhibit), 1);
        cyc(1);
        chk("R4 released after recovery", int'(tx_inhibit), 0);

        read_clear();
        chk("R8 status cleared by read", int'(status), 0);
        chk("R11 irq cleared", int'(irq), 0);

        // R5: ports without jabber check
        port_sel = 2'd0; tx_active = 1'b1; cyc(3 * J);
        chk("R5 coax no inhibit", int'(tx_inhibit), 0);
        port_sel = 2'd3; cyc(3 * J);
        chk("R5 serial no flag", int'(status[0]), 0);
        tx_active = 1'b0; cyc(1);

        // R2 on direct port, then R5 port switch ends the cut
        port_sel = 2'd2; tx_active = 1'b1; cyc(J);
        chk("R2 direct port trips", int'(tx_inhibit), 1);
        port_sel = 2'd0; cyc(1);
        chk("R5 switch ends inhibit", int'(tx_inhibit), 0);
        chk("R5 flag kept after switch", int'(status[0]), 1);
        tx_active = 1'b0; cyc(1);
        read_clear();

        // R6: oversize frame on a port without jabber check
        send_frame(25, -1);
        chk("R6 babble flag", int'(status[1]), 1);
        chk("R6 no inhibit from babble", int'(tx_inhibit), 0);
        read_clear();

        // R7: idle strobes ignored, count restarts per frame
        for (int i = 0; i < 30; i++) begin
            byte_stb = 1'b1; cyc(1); byte_stb = 1'b0; cyc(1);
        end
        send_frame(M - 1, -1);
        chk("R7 idle strobes not counted", int'(status[1]), 0);
        send_frame(M - 1, -1);
        chk("R7 count restarts per frame", int'(status[1]), 0);
        send_frame(M, -1);
        chk("R6 exact limit sets babble", int'(status[1]), 1);
        read_clear();

        // R9: read in the event cycle
        send_frame(M, M - 1);
        chk("R9 event survives read", int'(status[1]), 1);

        // R10: software reset during a cut
        port_sel = 2'd1; tx_active = 1'b1; cyc(J);
        chk("R10 cut before soft reset", int'(tx_inhibit), 1);
        sw_rst = 1'b1; cyc(1); sw_rst = 1'b0;
        chk("R10 inhibit cleared", int'(tx_inhibit), 0);
        chk("R10 status cleared", int'(status), 0);
        chk("R10 irq cleared", int'(irq), 0);
        tx_active = 1'b0; cyc(5);

        finish_run();
    end

endmodule